// File: doc/BRIEF.md
# Sequence-Keyed Watchdog Timer

This block is a timeout monitor for a processor subsystem. Software switches it on with a one-cycle enable strobe. From then on it counts down a fixed number of clock cycles. To stay alive, software must feed it by writing two bytes in a row to its restart register: first 1Eh, then E1h. Any other traffic on that register breaks a half-written pair. Writes to the other register select are ignored.

If the countdown runs out, the block sends a single-cycle expiry strobe to the reset controller, which stretches it into a reset pulse. It also raises a sticky overflow status bit. After an expiry the counter freezes until the next system reset. Every reset leaves the block switched off, including a reset that the block itself caused. Software must switch it on again if it wants protection.

Top module: `wdt_seq_guard`

## Requirements
- R1: After `rst_n` is released, `expire_o` and `ovf_o` are 0 and the timer is disabled.
- R2: An `en_set` pulse while disabled enables the timer and loads the full timeout TIMEOUT. With no restart, `expire_o` is high in the cycle that follows the TIMEOUT-th rising edge after the enabling edge.
- R3: A write of 1Eh followed, on the very next write to the restart register (`wr_sel`=1), by E1h reloads the counter on the E1h edge. Expiry then comes TIMEOUT edges after that edge.
- R4: A write of E1h to the restart register that is not directly preceded there by 1Eh has no effect on the count.
- R5: Any value other than 1Eh or E1h written to the restart register between 1Eh and E1h discards the pending pair.
- R6: Writing 1Eh two or more times in a row keeps the pair pending, so a following E1h still restarts the count.
- R7: Writes with `wr_sel`=0 neither restart the count nor disturb a pending 1Eh.
- R8: The expiry strobe lasts exactly one cycle. `ovf_o` goes high with it and stays high. The counter then stops, and neither restarts nor a second expiry occur until reset.
- R9: While the timer is disabled no expiry occurs, and restart pairs neither enable it nor lead to an expiry.
- R10: A restart that completes on the same edge at which the count would run out takes priority: no strobe is issued and the full timeout is reloaded.
- R11: An `en_set` pulse while already enabled has no effect on the count.
- R12: A system reset clears the enable and the overflow bit, so after reset no expiry occurs until `en_set` is pulsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 1 selects the restart register, 0 selects another register (ignored) |
| wr_data | input | 8 | Write data byte |
| en_set | input | 1 | One-cycle request to switch the timer on |
| expire_o | output | 1 | One-cycle expiry strobe to the reset controller |
| ovf_o | output | 1 | Sticky overflow status, set at expiry |

## Verification
Completion of the restart pair and the final step of the countdown can fall on the same clock edge. The bench provokes this by sweeping where the E1h write lands, from well inside the timeout to two edges past it. The expected expiry edge is computed from arithmetic on the enable and restart edges. On the colliding edge the restart must win, so a strobe is expected only one full timeout later. Once the write lands after the expiry edge, exactly one strobe is expected, at the original deadline, and the late write must be ignored.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0] KEY_ARM     = 8'h1E;
    localparam logic [7:0] KEY_FIRE    = 8'h E1;
    localparam logic       SEL_RESTART = 1'b1;

    typedef struct packed {
        logic armed;
    } seq_state_t;
endpackage

// File: rtl/wdt_seq_det.sv
module wdt_seq_det
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    output logic       kick_o
);
    seq_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        kick_o = 1'b0;
        if (wr_en && (wr_sel == SEL_RESTART)) begin
            if (wr_data == KEY_ARM) begin
                s_d.armed = 1'b1;
            end else begin
                if ((wr_data == KEY_FIRE) && s_q.armed) begin
                    kick_o = 1'b1;
                end
                s_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: a completed pair consumes the pending first byte
    p_fire_consumes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        kick_o |=> !s_q.armed);

    // R7: a write to the other register select leaves the pending state alone
    p_other_sel_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel != SEL_RESTART)) |=> $stable(s_q.armed));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int TIMEOUT = 1024,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_set,
    input  logic kick,
    output logic expire_o,
    output logic ovf_o
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(TIMEOUT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    typedef struct packed {
        logic             en;
        logic [CNT_W-1:0] cnt;
        logic             exp;
        logic             ovf;
    } tmr_state_t;

    tmr_state_t t_d, t_q;
    logic       halted;

    always_comb begin
        t_d     = t_q;
        t_d.exp = 1'b0;
        halted  = t_q.en && (t_q.cnt == '0);
        if (!t_q.en) begin
            if (en_set) begin
                t_d.en  = 1'b1;
                t_d.cnt = FULL;
            end
        end else if (!halted) begin
            if (kick) begin
                t_d.cnt = FULL;
            end else begin
                t_d.cnt = t_q.cnt - LAST;
                if (t_q.cnt == LAST) begin
                    t_d.exp = 1'b1;
                    t_d.ovf = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expire_o = t_q.exp;
    assign ovf_o    = t_q.ovf;

    // R2: switching on loads the full timeout
    p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_q.en && en_set) |=> (t_q.en && (t_q.cnt == FULL)));

    // R3: a restart on a running counter reloads it
    p_kick_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && t_q.en && (t_q.cnt != '0)) |=> (t_q.cnt == FULL));

    // R8: the strobe is a single cycle
    p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.exp |=> !t_q.exp);

    // R8: overflow status is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.ovf |=> t_q.ovf);

    // R8: the counter stays frozen after expiry
    p_halt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(t_q.cnt) && t_q.en));

    // R9: a strobe only follows an enabled cycle
    p_expire_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.exp |-> $past(t_q.en));
endmodule

// File: rtl/wdt_seq_guard.sv
module wdt_seq_guard #(
    parameter int TIMEOUT = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       en_set,
    output logic       expire_o,
    output logic       ovf_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);

    logic kick;

    wdt_seq_det u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .kick_o  (kick)
    );

    wdt_timer #(
        .TIMEOUT (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set),
        .kick     (kick),
        .expire_o (expire_o),
        .ovf_o    (ovf_o)
    );

    // R1: nothing is signalled in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!expire_o && !ovf_o));

    // R8: a strobe always comes with the status bit
    p_strobe_sets_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> ovf_o);
endmodule

// File: tb/sim_wdt_seq_guard.sv
`timescale 1ns/1ps
module sim_wdt_seq_guard;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       en_set = 1'b0;
    logic       expire_o, ovf_o;

    int ecnt = 0;
    int exp_seen = 0;
    int last_exp = -1;
    int checks = 0;
    int fails = 0;

    wdt_seq_guard #(.TIMEOUT(T)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .en_set(en_set), .expire_o(expire_o), .ovf_o(ovf_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) ecnt <= ecnt + 1;

    always @(negedge clk) begin
        if (rst_n && expire_o) begin
            exp_seen <= exp_seen + 1;
            last_exp <= ecnt;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        #2;
        exp_seen = 0;
        last_exp = -1;
    endtask

    task automatic do_wr(input logic sel, input logic [7:0] d, output int e);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        e = ecnt;
        wr_en = 1'b0;
    endtask

    task automatic do_en(output int e);
        en_set = 1'b1;
        @(posedge clk); #1;
        e = ecnt;
        en_set = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", ecnt, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int e, w;
        do_reset();
        // R1: reset state
        @(negedge clk);
        chk(expire_o == 1'b0, "R1 expire after reset", expire_o, 0);
        chk(ovf_o == 1'b0, "R1 ovf after reset", ovf_o, 0);
        #1;
        idle(3 * T);
        chk(exp_seen == 0, "R9 no expiry while disabled", exp_seen, 0);

        // R9: restart pairs while disabled do nothing
        do_wr(1'b1, 8'h1E, w); do_wr(1'b1, 8'hE1, w);
        idle(3 * T);
        chk(exp_seen == 0, "R9 restart while disabled", exp_seen, 0);

        // R2: plain timeout
        do_en(e);
        idle(T + 3);
        chk(exp_seen == 1, "R2 one expiry", exp_seen, 1);
        chk(last_exp == e + T, "R2 expiry edge", last_exp, e + T);
        chk(ovf_o == 1'b1, "R8 ovf set", ovf_o, 1);

        // R8: frozen afterwards, restart ignored, status held
        do_wr(1'b1, 8'h1E, w); do_wr(1'b1, 8'hE1, w);
        en_set = 1'b1; idle(1); en_set = 1'b0;
        idle(3 * T);
        chk(exp_seen == 1, "R8 no second expiry", exp_seen, 1);
        chk(ovf_o == 1'b1, "R8 ovf sticky", ovf_o, 1);

        // R12: reset clears enable and status
        do_reset();
        chk(ovf_o == 1'b0, "R12 ovf cleared", ovf_o, 0);
        idle(3 * T);
        chk(exp_seen == 0, "R12 disabled after reset", exp_seen, 0);
        do_en(e);
        idle(T + 3);
        chk(last_exp == e + T, "R12 re-enable expiry", last_exp, e + T);

        // R3 / R10: sweep the restart edge across the deadline
        for (int k = 2; k <= T + 2; k++) begin
            int x;
            do_reset();
            do_en(e);
            idle(k - 2);
            do_wr(1'b1, 8'h1E, w);
            do_wr(1'b1, 8'hE1, w);
            idle(2 * T + 3);
            x = (k <= T) ? e + k + T : e + T;
            chk(w == e + k, "R10 sweep write edge", w, e + k);
            chk(exp_seen == 1, "R10 single strobe", exp_seen, 1);
            chk(last_exp == x, (k == T) ? "R10 restart wins tie" : "R3 expiry edge", last_exp, x);
        end

        // R4: lone E1h
        do_reset();
        do_en(e);
        idle(1);
        do_wr(1'b1, 8'hE1, w);
        idle(T + 3);
        chk(last_exp == e + T, "R4 lone E1h ignored", last_exp, e + T);

        // R5 / R6: every byte between the pair
        for (int v = 0; v < 256; v++) begin
            int r, w1, w3;
            do_reset();
            do_en(e);
            do_wr(1'b1, 8'h1E, w1);
            do_wr(1'b1, v[7:0], w);
            do_wr(1'b1, 8'hE1, w3);
            if (v == 8'h1E)      r = w3;
            else if (v == 8'hE1) r = w;
            else                 r = e;
            idle(2 * T + 2);
            chk(last_exp == r + T && exp_seen == 1,
                (v == 8'h1E) ? "R6 repeated 1Eh" : "R5 intervening byte", last_exp, r + T);
        end

        // R7: other register select
        do_reset();
        do_en(e);
        do_wr(1'b0, 8'h1E, w);
        do_wr(1'b0, 8'hE1, w);
        idle(T + 3);
        chk(last_exp == e + T, "R7 other select no restart", last_exp, e + T);
        do_reset();
        do_en(e);
        do_wr(1'b1, 8'h1E, w);
        do_wr(1'b0, 8'h55, w);
        do_wr(1'b1, 8'hE1, w);
        idle(2 * T + 2);
        chk(last_exp == w + T, "R7 pending pair kept", last_exp, w + T);

        // R11: second enable ignored
        do_reset();
        do_en(e);
        idle(3);
        do_en(w);
        idle(T + 3);
        chk(last_exp == e + T, "R11 enable while enabled", last_exp, e + T);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule